// File: doc/BRIEF.md
# Eight-Channel PCM Register Interface

This block is the host-facing register file of an eight-channel wave playback engine. The host writes one byte at a time to a 4-bit register address. Most of these writes go indirectly to the channel that a pointer currently selects. That channel receives an 8-bit envelope, a pair of 4-bit pan levels, a 16-bit frequency step, a 16-bit loop start and a start address. A control register sets the global enable. Depending on a select bit, the same register loads either the channel pointer or the wave-memory bank. A further register turns each channel on or off.

A write to the start address also reloads that channel's live playback pointer with the start address scaled by 2^11. The sample engine downstream uses this pointer. The block also translates a 4 KB host window into a 64 KB wave memory. The selected bank supplies the upper four address bits. The block provides a second address, one higher and wrapping at 64 KB, for the upper byte of a 16-bit access. Every channel field can be read back through a channel-select port, so the playback engine or the host can observe the stored state.

Top module: `pcm_chan_regs`

## Requirements
- R1: After reset every channel holds envelope 0x80, both pan levels 8, and zero in step, loop start, start address and live pointer. All channels are off, the global enable is 0, and the channel pointer and bank are 0.
- R2: A strobed write to register 0 sets the envelope of the channel that the pointer selects, and only that channel. The value is visible one cycle later.
- R3: A write to register 1 sets left pan from data bits 3:0 and right pan from data bits 7:4 of the selected channel.
- R4: Registers 2 and 3 write the low byte and the high byte of the selected channel's 16-bit frequency step. The other byte is left unchanged.
- R5: Registers 4 and 5 write the low byte and the high byte of the selected channel's 16-bit loop start. The other byte is left unchanged.
- R6: A write to register 6 sets the selected channel's start address to {data, 0x00}. In the same cycle it loads that channel's 27-bit live pointer with the start address shifted left by 11.
- R7: A write to register 7 sets the global enable from data bit 7. When bit 6 is 1, bits 2:0 load the channel pointer and the bank is kept. When bit 6 is 0, bits 3:0 load the bank and the pointer is kept.
- R8: A write to register 8 sets the on/off state of every channel at once. Data bit i equal to 0 turns channel i on, and 1 turns it off. The output ch_on reports 1 for a channel that is on.
- R9: Writes to register addresses 9 to 15 change no state. Without the reg_we strobe, no register changes.
- R10: wave_addr equals {bank, host_addr[11:0]}. wave_addr_nxt equals wave_addr + 1 modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write byte |
| host_addr | input | 12 | Host window byte address |
| rd_ch | input | 3 | Channel selected for readback |
| master_on | output | 1 | Global enable |
| cur_ch | output | 3 | Channel pointer for indirect writes |
| bank | output | 4 | Wave-memory bank |
| ch_on | output | 8 | Per-channel on state, 1 = on |
| wave_addr | output | 16 | Wave-memory address of the host access |
| wave_addr_nxt | output | 16 | Address of the upper byte of a 16-bit access |
| rd_env | output | 8 | Envelope of rd_ch |
| rd_pan_l | output | 4 | Left pan of rd_ch |
| rd_pan_r | output | 4 | Right pan of rd_ch |
| rd_step | output | 16 | Frequency step of rd_ch |
| rd_loop | output | 16 | Loop start of rd_ch |
| rd_start | output | 16 | Start address of rd_ch |
| rd_live | output | 27 | Live playback pointer of rd_ch |

## Verification
The first pattern fills one channel with asymmetric bytes in every field. This separates byte lanes, pan nibble order and the start-to-live shift. A sweep then retargets the pointer across all eight channels and writes distinct values to each one. Because readback cycles through every channel on each clock, a write that lands on the wrong channel or on several channels is caught. Control writes alternate the select bit, so a pointer update that disturbs the bank, or the reverse, shows up. Patterns to the on/off register, writes to the unused addresses, unstrobed writes, and host addresses at the top of the window in the top bank cover the inversion, the ignore rule and the 64 KB wrap.

// File: rtl/pcm_chan_regs.sv
module pcm_chan_regs #(
  parameter int NCH   = 8,
  parameter int BANKW = 4,
  parameter int WINW  = 12,
  parameter int SHIFT = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [3:0]              reg_addr,
  input  logic [7:0]              reg_wdata,
  input  logic [WINW-1:0]         host_addr,
  input  logic [$clog2(NCH)-1:0]  rd_ch,
  output logic                    master_on,
  output logic [$clog2(NCH)-1:0]  cur_ch,
  output logic [BANKW-1:0]        bank,
  output logic [NCH-1:0]          ch_on,
  output logic [BANKW+WINW-1:0]   wave_addr,
  output logic [BANKW+WINW-1:0]   wave_addr_nxt,
  output logic [7:0]              rd_env,
  output logic [3:0]              rd_pan_l,
  output logic [3:0]              rd_pan_r,
  output logic [15:0]             rd_step,
  output logic [15:0]             rd_loop,
  output logic [15:0]             rd_start,
  output logic [16+SHIFT-1:0]     rd_live
);
  localparam int CHW   = $clog2(NCH);
  localparam int AW    = BANKW + WINW;
  localparam int LIVEW = 16 + SHIFT;

  logic [7:0]       env_q   [NCH];
  logic [3:0]       panl_q  [NCH];
  logic [3:0]       panr_q  [NCH];
  logic [15:0]      step_q  [NCH];
  logic [15:0]      loop_q  [NCH];
  logic [7:0]       start_q [NCH];
  logic [LIVEW-1:0] live_q  [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        env_q[i]   <= 8'h80;
        panl_q[i]  <= 4'd8;
        panr_q[i]  <= 4'd8;
        step_q[i]  <= '0;
        loop_q[i]  <= '0;
        start_q[i] <= '0;
        live_q[i]  <= '0;
      end
    end else if (reg_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (cur_ch == CHW'(i)) begin
          case (reg_addr)
            4'd0: env_q[i] <= reg_wdata;
            4'd1: begin
              panl_q[i] <= reg_wdata[3:0];
              panr_q[i] <= reg_wdata[7:4];
            end
            4'd2: step_q[i][7:0]  <= reg_wdata;
            4'd3: step_q[i][15:8] <= reg_wdata;
            4'd4: loop_q[i][7:0]  <= reg_wdata;
            4'd5: loop_q[i][15:8] <= reg_wdata;
            4'd6: begin
              start_q[i] <= reg_wdata;
              live_q[i]  <= {reg_wdata, 8'h00, {SHIFT{1'b0}}};
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_on <= 1'b0;
      cur_ch    <= '0;
      bank      <= '0;
      ch_on     <= '0;
    end else if (reg_we) begin
      if (reg_addr == 4'd7) begin
        master_on <= reg_wdata[7];
        if (reg_wdata[6]) cur_ch <= reg_wdata[CHW-1:0];
        else              bank   <= reg_wdata[BANKW-1:0];
      end else if (reg_addr == 4'd8) begin
        ch_on <= ~reg_wdata[NCH-1:0];
      end
    end
  end

  assign wave_addr     = {bank, host_addr};
  assign wave_addr_nxt = wave_addr + AW'(1);

  assign rd_env   = env_q[rd_ch];
  assign rd_pan_l = panl_q[rd_ch];
  assign rd_pan_r = panr_q[rd_ch];
  assign rd_step  = step_q[rd_ch];
  assign rd_loop  = loop_q[rd_ch];
  assign rd_start = {start_q[rd_ch], 8'h00};
  assign rd_live  = live_q[rd_ch];

  a_r2_env_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd0) |=> env_q[$past(cur_ch)] == $past(reg_wdata));

  a_r6_live_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd6) |=>
      live_q[$past(cur_ch)] == {$past(reg_wdata), 8'h00, {SHIFT{1'b0}}});

  a_r7_pointer_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd7 && reg_wdata[6]) |=> $stable(bank));

  a_r7_bank_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd7 && !reg_wdata[6]) |=> $stable(cur_ch));

  a_r8_onoff_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd8) |=> ch_on == ~$past(reg_wdata[NCH-1:0]));

  a_r9_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr >= 4'd9) |=>
      $stable(ch_on) && $stable(bank) && $stable(cur_ch) && $stable(master_on));
endmodule

// File: tb/pcm_chan_regs_test.sv
module pcm_chan_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [11:0] host_addr = 0;
  logic [2:0]  rd_ch = 0;
  logic        master_on;
  logic [2:0]  cur_ch;
  logic [3:0]  bank;
  logic [7:0]  ch_on;
  logic [15:0] wave_addr, wave_addr_nxt;
  logic [7:0]  rd_env;
  logic [3:0]  rd_pan_l, rd_pan_r;
  logic [15:0] rd_step, rd_loop, rd_start;
  logic [26:0] rd_live;

  int checks = 0, failures = 0;
  bit done = 0, active = 0, in_reset = 1;

  int m_env[8], m_pl[8], m_pr[8], m_step[8], m_loop[8], m_start[8], m_live[8];
  int m_master, m_cur, m_bank, m_on;

  pcm_chan_regs uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tg(string t);
    return in_reset ? "R1" : t;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_env[i] = 'h80; m_pl[i] = 8; m_pr[i] = 8;
      m_step[i] = 0; m_loop[i] = 0; m_start[i] = 0; m_live[i] = 0;
    end
    m_master = 0; m_cur = 0; m_bank = 0; m_on = 0;
  endtask

  task automatic model_write(int a, int d);
    case (a)
      0: m_env[m_cur] = d;
      1: begin m_pl[m_cur] = d & 15; m_pr[m_cur] = d >> 4; end
      2: m_step[m_cur] = (m_step[m_cur] & 'hff00) | d;
      3: m_step[m_cur] = (m_step[m_cur] & 'h00ff) | (d << 8);
      4: m_loop[m_cur] = (m_loop[m_cur] & 'hff00) | d;
      5: m_loop[m_cur] = (m_loop[m_cur] & 'h00ff) | (d << 8);
      6: begin m_start[m_cur] = d << 8; m_live[m_cur] = (d << 8) << 11; end
      7: begin
        m_master = (d >> 7) & 1;
        if ((d >> 6) & 1) m_cur = d & 7; else m_bank = d & 15;
      end
      8: m_on = (~d) & 'hff;
      default: ;
    endcase
  endtask

  // Reference comparison on every clock, away from the active edge
  always @(negedge clk) if (active) begin
    chk(tg("R2"), rd_env, m_env[rd_ch]);
    chk(tg("R3"), rd_pan_l, m_pl[rd_ch]);
    chk(tg("R3"), rd_pan_r, m_pr[rd_ch]);
    chk(tg("R4"), rd_step, m_step[rd_ch]);
    chk(tg("R5"), rd_loop, m_loop[rd_ch]);
    chk(tg("R6"), rd_start, m_start[rd_ch]);
    chk(tg("R6"), rd_live, m_live[rd_ch]);
    chk(tg("R7"), master_on, m_master);
    chk(tg("R7"), cur_ch, m_cur);
    chk(tg("R7"), bank, m_bank);
    chk(tg("R8"), ch_on, m_on);
    chk(tg("R10"), wave_addr, (m_bank << 12) | host_addr);
    chk(tg("R10"), wave_addr_nxt, ((m_bank << 12) + host_addr + 1) & 'hffff);
  end

  always @(posedge clk) begin
    #1 rd_ch = rd_ch + 3'd1;
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(posedge clk); #1;
    model_write(a, d);
    reg_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    model_reset();
    active = 1;
    idle(3);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk); in_reset = 0;
    idle(8);
    // R2..R6: one channel, asymmetric bytes
    wr(7, 'hC3);
    wr(0, 'h5A); wr(1, 'h9C); wr(2, 'h34); wr(3, 'h12);
    wr(4, 'h78); wr(5, 'h56); wr(6, 'hA5);
    wr(2, 'hEE); wr(5, 'h01);
    // R7: bank write keeps pointer
    wr(7, 'h05);
    wr(0, 'h11);
    // sweep all channels
    for (int c = 0; c < 8; c++) begin
      wr(7, 'h40 | c);
      wr(0, c * 17 + 3);
      wr(1, (c << 4) | (15 - c));
      wr(3, 'h80 | c);
      wr(4, c * 9);
      wr(6, 'hF0 ^ c);
    end
    idle(8);
    // R8 patterns
    wr(8, 'hA5); idle(2);
    wr(8, 'h00); idle(2);
    wr(8, 'hFF); idle(2);
    wr(8, 'h3C);
    // R9: unused addresses and unstrobed write
    for (int a = 9; a < 16; a++) wr(a, 'hFF);
    chk("R9", ch_on, 'hC3);
    chk("R9", bank, 5);
    @(posedge clk); #1 reg_addr = 4'd8; reg_wdata = 8'h00;
    @(posedge clk); #1 reg_addr = 4'd7; reg_wdata = 8'h4F;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R9", ch_on, 'hC3);
    chk("R9", cur_ch, 7);
    chk("R9", master_on, 0);
    // R10: window mapping and wrap
    wr(7, 'h8F);
    host_addr = 12'hFFF; @(negedge clk);
    chk("R10", wave_addr_nxt, 0);
    chk("R10", wave_addr, 'hFFFF);
    @(posedge clk); #1 host_addr = 12'h7FF;
    wr(7, 'h02);
    @(posedge clk); #1 host_addr = 12'h000;
    wr(7, 'h0A);
    @(posedge clk); #1 host_addr = 12'hABC;
    idle(10);
    @(negedge clk);
    active = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule